// File: doc/BRIEF.md
# ADC External Trigger Conditioner

This block turns an asynchronous start pin into conversion-start requests for an ADC sequencer. The pin is brought into the peripheral clock domain by a two-flop synchronizer. A saturating 8-bit run counter then measures how long the synchronized sample has stayed at its present value. That measurement qualifies four trigger conditions: low level, high level, falling edge and rising edge.

In a level condition the block asks for one conversion after the level has been seen on eight consecutive samples. It asks again after every conversion-done for as long as the level remains. In an edge condition it asks once, and only when the phases on both sides of the edge each lasted at least four samples. Shorter pulses are treated as glitches. The sequencer receives a one-cycle start pulse. It answers with a busy level while converting and a one-cycle done pulse at the end.

Top module: `adc_ext_trig`

## Requirements
- R1: While reset is held and after it is released, `start_req` is 0 until a trigger condition qualifies again.
- R2: The path is active only when `trig_en` is 1, `src_sel` is 2'b00 and `single_scan` is 1. In any other setting no start is issued, and the run counter and phase state are cleared.
- R3: `cond_sel` encodes 2'b00 low level, 2'b01 high level, 2'b10 falling edge and 2'b11 rising edge.
- R4: The pin passes through two synchronizer flops. The filter counts synchronized samples in an 8-bit counter that saturates at 255.
- R5: Level condition: a pin that changes to the selected level before clock edge 1 and stays there raises `start_req` in the cycle after edge 10, which is the cycle after the eighth matching sample. A level held for fewer than 8 samples gives no start.
- R6: Level condition: after `conv_done` is sampled high at edge d, and while the level is still qualified, a new start is raised after edge d+1. No start is issued in a cycle where `conv_busy` is 1, nor while a conversion it started has not yet reported done.
- R7: Edge condition: when the pin enters the selected new level before edge 1, `start_req` rises after edge 6, which is the cycle after the fourth sample of the new phase. This requires that the previous phase lasted at least 4 samples.
- R8: Edge condition: a high or low phase shorter than 4 samples on either side of the edge gives no start.
- R9: Edge condition: an edge whose qualifying cycle falls while `conv_busy` is 1 is dropped and is not issued later.
- R10: Dropping the enable for a single cycle clears the run counter at once. A level that was being qualified then needs 8 fresh samples.
- R11: `start_req` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_en | input | 1 | External trigger enable |
| src_sel | input | 2 | Trigger source select; 2'b00 selects the pin |
| cond_sel | input | 2 | Trigger condition (see R3) |
| single_scan | input | 1 | High when the converter runs single-cycle scan |
| ext_pin | input | 1 | Asynchronous external start pin |
| conv_busy | input | 1 | Conversion in progress |
| conv_done | input | 1 | One-cycle conversion-complete pulse |
| start_req | output | 1 | One-cycle conversion-start pulse |

## Verification
The main sweep drives a single opposite-polarity pulse, 1 to 14 samples wide, out of a long idle phase. It runs under every condition, and in the edge conditions from both idle polarities. Pulse widths around 4 and 8 separate the edge threshold from the level threshold. The first-start cycle separates an edge taken at the front of a pulse from one taken at its back. The number of starts in long level pulses shows the re-arm after each done. Directed cases force busy across a qualifying cycle, drop the enable for one cycle partway through qualification, and hold a valid level with a wrong source or scan mode selected.

// File: rtl/adc_trig_pkg.sv
// Package: shared encodings for the external trigger conditioner.
// Assumes: condition and source fields are 2 bits wide.
package adc_trig_pkg;
    typedef enum logic [1:0] {
        COND_LOW  = 2'b00,
        COND_HIGH = 2'b01,
        COND_FALL = 2'b10,
        COND_RISE = 2'b11
    } trig_cond_e;

    localparam logic [1:0] SRC_EXT_PIN = 2'b00;
endpackage

// File: rtl/adc_trig_sync.sv
// Module: multi-stage synchronizer for the asynchronous start pin.
// Provides the final stage and the stage before it so that the filter can
// see a change one cycle ahead. Assumes STAGES >= 2.
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q_next,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Purpose: capture the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= din;
            end
        end else begin : g_rest
            // Purpose: pass the sample one stage down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q      = chain[STAGES-1];
    assign q_next = chain[STAGES-2];
endmodule

// File: rtl/adc_trig_filter.sv
// Module: run-length filter. Counts the cycles the synchronized sample has
// kept its current value, and records whether the phase before the last
// change was long enough for an edge. Assumes EDGE_MIN <= 2**CNT_W - 1.
module adc_trig_filter #(
    parameter int CNT_W    = 8,
    parameter int EDGE_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             samp_next,
    input  logic             samp,
    output logic [CNT_W-1:0] run_cnt,
    output logic             prev_long
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] EDGE_REF = CNT_W'(EDGE_MIN - 1);

    logic changing;
    assign changing = (samp_next != samp);

    // Purpose: saturating run counter, restarted on every sample change.
    always_ff @(posedge clk) begin
        if (!rst_n)             run_cnt <= '0;
        else if (!active)       run_cnt <= '0;
        else if (changing)      run_cnt <= '0;
        else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
    end

    // Purpose: remember whether the phase that just ended met the edge minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_long <= 1'b0;
        else if (!active)  prev_long <= 1'b0;
        else if (changing) prev_long <= (run_cnt >= EDGE_REF);
    end
endmodule

// File: rtl/adc_trig_decide.sv
// Module: decides when to request a conversion from the run length, the
// selected condition and the converter handshake. Holds a wait flag from a
// request until the matching done so that one request maps to one conversion.
module adc_trig_decide
    import adc_trig_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LEVEL_MIN = 8,
    parameter int EDGE_MIN  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  trig_cond_e       cond,
    input  logic             samp,
    input  logic [CNT_W-1:0] run_cnt,
    input  logic             prev_long,
    input  logic             conv_busy,
    input  logic             conv_done,
    output logic             start_req
);
    localparam logic [CNT_W-1:0] LVL_REF  = CNT_W'(LEVEL_MIN - 1);
    localparam logic [CNT_W-1:0] EDGE_REF = CNT_W'(EDGE_MIN - 1);

    logic level_mode, target, hit, lvl_ok, edge_ok, fire, awaiting;

    // Purpose: decode the condition and qualify the current sample run.
    always_comb begin
        level_mode = (cond == COND_LOW) || (cond == COND_HIGH);
        target     = (cond == COND_HIGH) || (cond == COND_RISE);
        hit        = (samp == target);
        lvl_ok     = level_mode && hit && (run_cnt >= LVL_REF);
        edge_ok    = !level_mode && hit && (run_cnt == EDGE_REF) && prev_long;
        fire       = active && (lvl_ok || edge_ok) && !awaiting && !conv_busy;
    end

    // Purpose: block further requests until the converter reports done.
    always_ff @(posedge clk) begin
        if (!rst_n)         awaiting <= 1'b0;
        else if (!active)   awaiting <= 1'b0;
        else if (fire)      awaiting <= 1'b1;
        else if (conv_done) awaiting <= 1'b0;
    end

    // Purpose: register the one-cycle start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) start_req <= 1'b0;
        else        start_req <= fire;
    end
endmodule

// File: rtl/adc_ext_trig.sv
// Module: external trigger conditioner top. Synchronizes the pin, filters it
// and issues conversion-start pulses. Assumes the sequencer raises conv_busy
// during a conversion and pulses conv_done for one cycle at its end.
module adc_ext_trig
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8,
    parameter int LEVEL_MIN   = 8,
    parameter int EDGE_MIN    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_en,
    input  logic [1:0] src_sel,
    input  logic [1:0] cond_sel,
    input  logic       single_scan,
    input  logic       ext_pin,
    input  logic       conv_busy,
    input  logic       conv_done,
    output logic       start_req
);
    logic             active;
    logic             samp_next, samp;
    logic [CNT_W-1:0] run_cnt;
    logic             prev_long;
    trig_cond_e       cond;

    assign active = trig_en && (src_sel == SRC_EXT_PIN) && single_scan;
    assign cond   = trig_cond_e'(cond_sel);

    adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (ext_pin),
        .q_next (samp_next),
        .q      (samp)
    );

    adc_trig_filter #(.CNT_W(CNT_W), .EDGE_MIN(EDGE_MIN)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .samp_next (samp_next),
        .samp      (samp),
        .run_cnt   (run_cnt),
        .prev_long (prev_long)
    );

    adc_trig_decide #(.CNT_W(CNT_W), .LEVEL_MIN(LEVEL_MIN), .EDGE_MIN(EDGE_MIN)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .cond      (cond),
        .samp      (samp),
        .run_cnt   (run_cnt),
        .prev_long (prev_long),
        .conv_busy (conv_busy),
        .conv_done (conv_done),
        .start_req (start_req)
    );
endmodule

// File: rtl/adc_ext_trig_chk.sv
// Module: property checker for the trigger conditioner, bound to the top.
// Watches only the top-level ports.
module adc_ext_trig_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_en,
    input logic [1:0] src_sel,
    input logic       single_scan,
    input logic       conv_busy,
    input logic       conv_done,
    input logic       start_req
);
    logic act, pend;
    assign act = trig_en && (src_sel == 2'b00) && single_scan;

    // Purpose: track a start that has not yet been answered by a done.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend <= 1'b0;
        else if (conv_done || !act)  pend <= 1'b0;
        else if (start_req)          pend <= 1'b1;
    end

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> !start_req);

    p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !start_req);

    p_busy_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> !start_req);

    p_await_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !start_req);
endmodule

bind adc_ext_trig adc_ext_trig_chk u_chk (.*);

// File: tb/tb_adc_ext_trig.sv
// Bench: pulse-width sweep over every condition plus directed gating, busy
// and enable-drop cases. Includes a simple converter model.
module tb_adc_ext_trig;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_en = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic [1:0] cond_sel = 2'b00;
    logic       single_scan = 1'b1;
    logic       ext_pin = 1'b0;
    logic       busy_m = 1'b0;
    logic       busy_force = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_busy;
    logic       start_req;

    int n_cmp = 0;
    int n_bad = 0;
    int adc_t = 0;

    assign conv_busy = busy_m | busy_force;

    always #5 clk = ~clk;

    adc_ext_trig dut (
        .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .src_sel(src_sel),
        .cond_sel(cond_sel), .single_scan(single_scan), .ext_pin(ext_pin),
        .conv_busy(conv_busy), .conv_done(conv_done), .start_req(start_req)
    );

    // Converter model: busy for three sampled edges, then a one-cycle done.
    always @(negedge clk) begin
        if (!rst_n) begin
            adc_t = 0; busy_m = 1'b0; conv_done = 1'b0;
        end else if (adc_t == 0) begin
            if (start_req) begin busy_m = 1'b1; adc_t = 1; end
        end else if (adc_t < 3) begin
            adc_t = adc_t + 1;
        end else if (adc_t == 3) begin
            busy_m = 1'b0; conv_done = 1'b1; adc_t = 4;
        end else begin
            conv_done = 1'b0; adc_t = 0;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One pulse of width w opposite to base, after a long base phase.
    task automatic run_case(input int cond, input int base, input int w,
                            input int src, input int scan, input int dis_k,
                            input int busy_until, input int exp_n,
                            input int exp_first, input string req);
        int n = 0;
        int first = 0;
        trig_en = 1'b0; ext_pin = base[0]; src_sel = 2'(src);
        single_scan = scan[0]; cond_sel = 2'(cond); busy_force = 1'b0;
        repeat (3) @(negedge clk);
        trig_en = 1'b1;
        repeat (20) @(negedge clk);
        if (busy_until > 0) busy_force = 1'b1;
        ext_pin = ~base[0];
        for (int k = 1; k <= w + 30; k++) begin
            @(negedge clk);
            if (start_req) begin
                n++;
                if (first == 0) first = k;
            end
            if (k == w) ext_pin = base[0];
            if (dis_k > 0 && k == dis_k) trig_en = 1'b0;
            if (dis_k > 0 && k == dis_k + 1) trig_en = 1'b1;
            if (k == busy_until) busy_force = 1'b0;
        end
        check(req, $sformatf("cond=%0d base=%0d w=%0d start count", cond, base, w), n, exp_n);
        check(req, $sformatf("cond=%0d base=%0d w=%0d first start edge", cond, base, w), first, exp_first);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int en, ef;
        repeat (4) @(negedge clk);
        check("R1", "start during reset", int'(start_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "start after reset", int'(start_req), 0);

        // Sweep: R3 encoding, R4 sync latency, R5 R6 level, R7 R8 edge.
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 2; b++) begin
                if (c < 2 && b == (c & 1)) continue;
                for (int w = 1; w <= 14; w++) begin
                    if (c < 2) begin
                        en = (w >= 8) ? (w - 8) / 5 + 1 : 0;
                        ef = (en > 0) ? 10 : 0;
                        run_case(c, b, w, 0, 1, 0, 0, en, ef, "R3 R4 R5 R6");
                    end else begin
                        en = (w >= 4) ? 1 : 0;
                        ef = (en == 0) ? 0 : (((1 - b) == (c & 1)) ? 6 : w + 6);
                        run_case(c, b, w, 0, 1, 0, 0, en, ef, "R3 R7 R8");
                    end
                end
            end
        end

        // R10: enable dropped for one cycle after edge 5 restarts the count.
        run_case(1, 0, 12, 0, 1, 5, 0, 1, 14, "R10");
        // R6: busy held until edge 15, then back-to-back conversions.
        run_case(1, 0, 20, 0, 1, 0, 15, 2, 16, "R6");
        // R9: rising edge qualifies while busy and is dropped.
        run_case(3, 0, 8, 0, 1, 0, 10, 0, 0, "R9");
        // R2: wrong source and wrong scan mode.
        run_case(1, 0, 20, 1, 1, 0, 0, 0, 0, "R2");
        run_case(0, 1, 20, 2, 1, 0, 0, 0, 0, "R2");
        run_case(1, 0, 20, 0, 0, 0, 0, 0, 0, "R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule